// File: doc/BRIEF.md
# External Bus Access Sequencer with Wait

This block runs single read or write accesses for one chip select on an asynchronous external memory bus. An accepted request walks through a setup phase, a strobe pulse phase and a hold phase. Each phase has its own cycle count, and reads and writes have separate counts. A read pulls the read strobe low. A write pulls the write strobe low and drives the data bus from setup through hold. The block raises a one-cycle done pulse after the access; for a read, the captured data is valid with that pulse.

A slow device can stretch the pulse phase with an active-low wait input. The wait input passes through a two-flop synchroniser, and it is looked at only while a strobe is in its pulse phase. A 2-bit mode field picks how it is used:
- bit 1 clear: the wait input is ignored.
- frozen mode: the pulse count stops while the wait input is low.
- ready mode: the pulse may not end while the wait input is low.

After a read, a programmable float count, plus one turnaround cycle, must pass before a following write may begin its setup. That count keeps running down while the block is idle.

Top module: `ebus_seq`

## Requirements
- R1: In reset and right after it, bus_rd_n and bus_wr_n are 1, bus_doe is 0, rsp_done is 0 and req_ready is 1.
- R2: A read is accepted in a cycle with req_valid and req_ready both high. Its phases then follow that cycle:
  - cfg_rd_setup setup cycles.
  - cfg_rd_pulse cycles with bus_rd_n low.
  - cfg_rd_hold hold cycles.
  - rsp_done high for exactly one cycle after the last hold cycle.
  - rsp_rdata equal to the bus_din value present in the last cycle that bus_rd_n is low.
- R3: A write has the same phase sequence, using the cfg_wr_* counts, with bus_wr_n low during the pulse. bus_doe is high and bus_dout equals the request data while the strobe is low, and bus_addr holds the request address.
- R4: A setup or hold count of 0 skips that phase entirely. A pulse count of 0 acts as a pulse of one cycle.
- R5: When cfg_wait_mode bit 1 is 0 (values 00 and 01), ext_wait_n has no effect on any access.
- R6: ext_wait_n is used only during the pulse phase. A low level that reaches the logic during setup, hold or idle does not change the access timing.
- R7: With cfg_wait_mode = 10 (frozen), each pulse cycle in which the synchronised wait is low adds one cycle to the pulse. A pin level driven in cycle k takes effect in cycle k+2.
- R8: With cfg_wait_mode = 11 (ready), the pulse lasts the programmed count. If the synchronised wait is low when the count expires, the pulse continues until the cycle in which the synchronised wait is high, and that cycle is the last pulse cycle.
- R9: cfg_err is 1 exactly when cfg_wait_mode bit 1 is 1 and cfg_rd_hold or cfg_wr_hold is 0.
- R10: After a read, a write's setup starts no earlier than cfg_float + 1 cycles after the read's final cycle, and bus_doe stays 0 until then. Reads are never delayed by the float count.
- R11: The float count runs down while the block is idle. A write issued n cycles after the read's done cycle waits max(0, cfg_float - n) extra cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_rd_setup | input | CW | Read setup cycles |
| cfg_rd_pulse | input | CW | Read pulse cycles |
| cfg_rd_hold | input | CW | Read hold cycles |
| cfg_wr_setup | input | CW | Write setup cycles |
| cfg_wr_pulse | input | CW | Write pulse cycles |
| cfg_wr_hold | input | CW | Write hold cycles |
| cfg_float | input | CW | Data-float cycles after a read |
| cfg_wait_mode | input | 2 | 0x ignore, 10 frozen, 11 ready |
| cfg_err | output | 1 | Wait enabled with a zero hold count |
| ext_wait_n | input | 1 | Asynchronous active-low wait from the device |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Write data to the bus |
| bus_doe | output | 1 | Data bus drive enable |
| bus_din | input | DW | Read data from the bus |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-cycle access completion pulse |

## Verification
Counting the acceptance cycle as 0, the strobe of an access first goes low in cycle gap+setup+1, where gap is the remaining float delay for a write following a read. The done pulse follows the final hold cycle by one cycle, and wait-pin changes reach the pulse logic two cycles after they are driven. For each access, the driver works out the pulse length and the done cycle from these rules and the wait pattern it will apply, and queues them. The monitor samples on the falling edge: it counts strobe-low cycles and compares the count and the done cycle against the queued entry. bus_din is driven only while the read strobe is low, so a capture in the wrong cycle returns a recognisably wrong value.

// File: rtl/ebus_seq.sv
module ebus_seq #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [CW-1:0] cfg_rd_setup,
  input  logic [CW-1:0] cfg_rd_pulse,
  input  logic [CW-1:0] cfg_rd_hold,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic [CW-1:0] cfg_wr_pulse,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic [CW-1:0] cfg_float,
  input  logic [1:0]    cfg_wait_mode,
  output logic          cfg_err,
  input  logic          ext_wait_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_PULSE, S_HOLD} st_t;

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW:0]   FONE = (CW+1)'(1);

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW:0]   flt;
  logic          wr_q, fin, start;
  logic [1:0]    wsync;

  logic          dir, wait_lo, frz_hold, rdy_hold, gap_ok;
  logic [CW-1:0] s_len, p_len, h_len, p_first;

  assign dir      = (st == S_IDLE) ? req_write : wr_q;
  assign s_len    = dir ? cfg_wr_setup : cfg_rd_setup;
  assign p_len    = dir ? cfg_wr_pulse : cfg_rd_pulse;
  assign h_len    = dir ? cfg_wr_hold  : cfg_rd_hold;
  assign p_first  = (p_len == '0) ? '0 : p_len - ONE;
  assign wait_lo  = cfg_wait_mode[1] & ~wsync[1];
  assign frz_hold = wait_lo & ~cfg_wait_mode[0];
  assign rdy_hold = wait_lo &  cfg_wait_mode[0];
  assign gap_ok   = (flt <= FONE);
  assign start    = ((st == S_IDLE) && req_valid && !(req_write && !gap_ok)) ||
                    ((st == S_GAP) && gap_ok);

  assign req_ready = (st == S_IDLE);
  assign bus_rd_n  = !((st == S_PULSE) && !wr_q);
  assign bus_wr_n  = !((st == S_PULSE) &&  wr_q);
  assign bus_doe   = wr_q && (st == S_SETUP || st == S_PULSE || st == S_HOLD);
  assign cfg_err   = cfg_wait_mode[1] && (cfg_rd_hold == '0 || cfg_wr_hold == '0);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    fin   = 1'b0;
    if (start) begin
      if (s_len != '0) begin
        st_n  = S_SETUP;
        cnt_n = s_len - ONE;
      end else begin
        st_n  = S_PULSE;
        cnt_n = p_first;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) st_n = S_GAP;
        S_GAP: ;
        S_SETUP:
          if (cnt == '0) begin
            st_n  = S_PULSE;
            cnt_n = p_first;
          end else cnt_n = cnt - ONE;
        S_PULSE:
          if (!frz_hold) begin
            if (cnt != '0) cnt_n = cnt - ONE;
            else if (!rdy_hold) begin
              if (h_len != '0) begin
                st_n  = S_HOLD;
                cnt_n = h_len - ONE;
              end else begin
                st_n = S_IDLE;
                fin  = 1'b1;
              end
            end
          end
        S_HOLD:
          if (cnt == '0) begin
            st_n = S_IDLE;
            fin  = 1'b1;
          end else cnt_n = cnt - ONE;
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      flt       <= '0;
      wsync     <= 2'b11;
      bus_addr  <= '0;
      bus_dout  <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      wsync    <= {wsync[0], ext_wait_n};
      rsp_done <= fin;
      if (req_valid && req_ready) begin
        wr_q     <= req_write;
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
      end
      if (st == S_PULSE && st_n != S_PULSE && !wr_q) rsp_rdata <= bus_din;
      if (fin && !wr_q) flt <= {1'b0, cfg_float} + FONE;
      else if (flt != '0) flt <= flt - FONE;
    end
  end

  a_r6_setup_ignores_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETUP && cnt == '0) |=> (st == S_PULSE));

  a_r5_disabled_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && cnt == '0 && !cfg_wait_mode[1]) |=> (st != S_PULSE));

  a_r7_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && cfg_wait_mode == 2'b10 && !wsync[1]) |=> (st == S_PULSE && $stable(cnt)));

  a_r8_ready_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && cnt == '0 && cfg_wait_mode == 2'b11 && !wsync[1]) |=> (st == S_PULSE));

  a_r10_float_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (flt == '0));

  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/ebus_seq_tb.sv
`timescale 1ns/1ps
module ebus_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  rs = 1, rp = 2, rh = 1, ws = 1, wp = 2, wh = 1, fl = 0;
  logic [1:0]  wm = 2'b00;
  logic        ext_wait_n = 1'b1;
  logic        req_ready, cfg_err, bus_rd_n, bus_wr_n, bus_doe, rsp_done;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout, bus_din, rsp_rdata;

  assign bus_din = bus_rd_n ? 16'hDEAD : (bus_addr[15:0] ^ 16'h5A5A);

  ebus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_rd_setup(rs), .cfg_rd_pulse(rp), .cfg_rd_hold(rh),
    .cfg_wr_setup(ws), .cfg_wr_pulse(wp), .cfg_wr_hold(wh),
    .cfg_float(fl), .cfg_wait_mode(wm), .cfg_err(cfg_err),
    .ext_wait_n(ext_wait_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done));

  typedef struct {
    logic        w;
    logic [23:0] a;
    logic [15:0] d;
    int          plen;
    int          lat;
    int          acc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0, plen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  // monitor: pops expected items as accesses complete
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_rd_n || !bus_wr_n) begin
        plen++;
        if (plen == 1 && q.size() > 0) begin
          chk(bus_addr == q[0].a, {q[0].tag, " addr"}, 32'(bus_addr), 32'(q[0].a));
          if (q[0].w) begin
            chk(bus_doe == 1'b1, {q[0].tag, " doe"}, 32'(bus_doe), 1);
            chk(bus_dout == q[0].d, {q[0].tag, " dout"}, 32'(bus_dout), 32'(q[0].d));
          end
        end
      end
      if (rsp_done) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(plen == e.plen, {e.tag, " pulse"}, 32'(plen), 32'(e.plen));
          chk(cyc - e.acc == e.lat, {e.tag, " done cycle"}, 32'(cyc - e.acc), 32'(e.lat));
          if (!e.w)
            chk(rsp_rdata == (e.a[15:0] ^ 16'h5A5A), {e.tag, " rdata"}, 32'(rsp_rdata),
                32'(e.a[15:0] ^ 16'h5A5A));
        end
        plen = 0;
      end
    end
  end

  // driver: g = extra float gap, wait pin low from cycle k for L cycles after accept
  task automatic access(input logic w, input logic [23:0] a, input logic [15:0] d,
                        input int g, input int k, input int L, input string tag);
    exp_t e;
    int s, p, h, c, r, t;
    bit lo, en;
    s = w ? int'(ws) : int'(rs);
    p = w ? int'(wp) : int'(rp);
    h = w ? int'(wh) : int'(rh);
    if (p == 0) p = 1;
    en = wm[1] && L > 0;
    c = g + s + 1;
    r = p;
    forever begin
      lo = en && c >= k + 2 && c <= k + L + 1;
      if (lo && !wm[0]) c++;
      else if (r > 1) begin r--; c++; end
      else if (lo && wm[0]) c++;
      else break;
    end
    e.w = w; e.a = a; e.d = d; e.tag = tag;
    e.plen = c - (g + s + 1) + 1;
    e.lat = c + h + 1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    e.acc = cyc;
    q.push_back(e);
    if (L > 0 && k == 0) ext_wait_n = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
      if (t == 1) req_valid = 1'b0;
      if (L > 0 && t == k) ext_wait_n = 1'b0;
      if (L > 0 && t == k + L) ext_wait_n = 1'b1;
    end while (!rsp_done && t < 200);
    ext_wait_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_rd_n == 1 && bus_wr_n == 1, "R1 strobes in reset", {bus_rd_n, bus_wr_n}, 3);
    chk(bus_doe == 0, "R1 doe in reset", 32'(bus_doe), 0);
    chk(rsp_done == 0, "R1 done in reset", 32'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", 32'(req_ready), 1);

    // R2 / R3 basic accesses, R10 with zero float
    access(0, 24'h000123, 16'h0, 0, 0, 0, "R2 read");
    access(1, 24'h000456, 16'hBEEF, 0, 0, 0, "R3 write after read F=0 R10");
    rs = 2; rp = 3; rh = 2; ws = 3; wp = 1; wh = 2;
    access(1, 24'h00A0A0, 16'h1234, 0, 0, 0, "R3 write longer");
    access(0, 24'h00F00F, 16'h0, 0, 0, 0, "R2 read longer");

    // R4 zero-length phases
    rs = 0; rp = 0; rh = 0; ws = 0; wp = 0; wh = 0;
    idle(2);
    access(0, 24'h000777, 16'h0, 0, 0, 0, "R4 read zeros");
    idle(2);
    access(1, 24'h000888, 16'h5555, 0, 0, 0, "R4 write zeros");

    // R5 wait disabled
    rs = 1; rp = 3; rh = 1; ws = 1; wp = 3; wh = 1;
    wm = 2'b00;
    access(0, 24'h001111, 16'h0, 0, 1, 4, "R5 mode00 wait ignored");
    wm = 2'b01;
    access(0, 24'h001112, 16'h0, 0, 1, 4, "R5 mode01 wait ignored");

    // R7 frozen
    wm = 2'b10;
    access(0, 24'h002222, 16'h0, 0, 1, 4, "R7 frozen read");
    access(1, 24'h002223, 16'hC0DE, 0, 1, 2, "R7 frozen write");

    // R8 ready
    wm = 2'b11;
    access(0, 24'h003333, 16'h0, 0, 1, 4, "R8 ready read");
    access(0, 24'h003334, 16'h0, 0, 0, 1, "R8 ready early release");

    // R6 wait in setup and in hold
    rs = 3; rp = 2; rh = 3;
    wm = 2'b10;
    access(0, 24'h004444, 16'h0, 0, 0, 2, "R6 wait in setup");
    access(0, 24'h004445, 16'h0, 0, 4, 3, "R6 wait in hold");

    // R9 configuration flag
    wm = 2'b10; rh = 0; #1;
    chk(cfg_err == 1, "R9 zero hold with wait", 32'(cfg_err), 1);
    wm = 2'b00; #1;
    chk(cfg_err == 0, "R9 zero hold no wait", 32'(cfg_err), 0);
    wm = 2'b11; rh = 1; #1;
    chk(cfg_err == 0, "R9 holds nonzero", 32'(cfg_err), 0);

    // R10 float turnaround, R11 rundown
    wm = 2'b00; rs = 1; rp = 2; rh = 1; ws = 1; wp = 2; wh = 1; fl = 5;
    idle(1);
    access(0, 24'h005555, 16'h0, 0, 0, 0, "R10 read");
    access(1, 24'h005556, 16'hAAAA, 5, 0, 0, "R10 write right after read");
    access(0, 24'h005557, 16'h0, 0, 0, 0, "R10 read");
    access(0, 24'h005558, 16'h0, 0, 0, 0, "R10 read not delayed");
    idle(8);
    access(1, 24'h005559, 16'hBBBB, 0, 0, 0, "R11 write after full rundown");
    access(0, 24'h00555A, 16'h0, 0, 0, 0, "R11 read");
    idle(2);
    access(1, 24'h00555B, 16'hCCCC, 3, 0, 0, "R11 write after partial rundown");

    idle(3);
    chk(q.size() == 0, "R2 all responses seen", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule